// File: doc/BRIEF.md
# I2C Master Batch Transfer Engine

This block is a memory-mapped I2C master that moves bursts of up to 32 bytes without software work between bytes. Software fills a transmit window, selects one of four modes in the control word and writes a byte count. The engine then sends or receives the whole burst and raises pending flags as bytes and bursts complete. A combined register-read mode sends the device address, the register-address bytes, a repeated START and the device address with the read bit set, then receives the burst. All of this runs from a single count write.

The engine does not time SCL itself. It hands one bus action at a time (START, STOP, write one bit, read one bit) to a separate bit-timing block. It holds a request with a stable command until that block returns a one-cycle acknowledge, which carries the sampled SDA level for reads. Only single-master operation is covered.

The sequencer state machine has these states. IDLE waits for a command. START and STOP each issue one bus condition. HDR_W sends the header bytes with R/W=0 and SUB sends the register-address bytes. RESTART issues the repeated START and HDR_R sends the header again with R/W=1. TXDATA and RXDATA run the data burst.

The transitions are as follows. IDLE goes to START on a start edge, to STOP on a stop edge, and to HDR_W, TXDATA or RXDATA on an accepted count write, depending on the mode. HDR_W goes to SUB. SUB goes to RESTART in register-read mode and to TXDATA otherwise. RESTART goes to HDR_R, and HDR_R goes to RXDATA. The last data byte returns the machine to IDLE. A NAK with abort enabled takes any transmitting state to STOP, and STOP and START both return to IDLE.

Top module: `i2cb_top`

## Requirements
- R1: After reset every register reads 0, `bit_req` is low and `irq` is low.
- R2: Control word (word 0) has enable at bit 0, mode at bits 2:1, start at bit 3, stop at bit 4, last-NAK at bit 5 and NAK-abort at bit 6. With enable set, a 0-to-1 change of the start bit issues one START command (cmd 0), and the start-done pending bit 4 is set when that command completes. Holding the start bit high issues nothing more.
- R3: A 0-to-1 change of the stop bit, with enable set, issues one STOP command (cmd 1) and sets stop-done pending bit 5 when it completes.
- R4: In mode 0, writing N to the transmit count (word 3) sends window bytes 0..N-1, each as 8 WRITE commands (cmd 2) MSB first followed by one READ (cmd 3) of the ACK bit. Byte n sits in transmit word 16+n/4 at bits 8*(n%4)+7:8*(n%4), and byte 0 is the address byte.
- R5: In mode 1, writing N to the receive count (word 4) sends the valid header bytes (word 1) with bit 0 of the first byte forced to 0. It then sends the valid register bytes (word 2), issues a repeated START, sends the header again with bit 0 of the first byte forced to 1, and receives N bytes. In words 1 and 2, byte k sits at bits 8k+7:8k and is valid when bit 24+k is set; bytes go out lowest first, and invalid ones are skipped.
- R6: A received byte is 8 READs, MSB first, followed by a WRITE of the ACK bit. That bit is 0, except on the last byte of a burst when last-NAK is set, where it is 1. Byte n is stored in receive word 32+n/4 at bits 8*(n%4)+7:8*(n%4). Mode 2 receives with no header.
- R7: In mode 3, a transmit count write sends the R/W=0 header and the valid register bytes before the window bytes.
- R8: Pending word 6 bits are: 0 byte sent, 1 byte received, 2 transmit burst done, 3 receive burst done, 4 start done, 5 stop done, 6 NAK. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: An ACK slot that reads 1 sets NAK pending. Without NAK-abort the burst continues. With NAK-abort the burst ends, a STOP is issued and the transmit-burst-done flag is not raised.
- R10: `irq` is high exactly when some bit is set in both pending and interrupt enable (word 5, same bit layout).
- R11: A count write is ignored when enable is clear, when the count is 0, or when the mode does not use that direction (transmit count in modes 1 and 2, receive count in modes 0 and 3).
- R12: `bit_req` stays high with `bit_cmd` and `bit_wdata` stable until `bit_ack`, and commands are issued in exactly the order the requirements above define.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| bit_req | output | 1 | Bus command request to the bit-timing block |
| bit_cmd | output | 2 | 0 START, 1 STOP, 2 write bit, 3 read bit |
| bit_wdata | output | 1 | SDA level for a write-bit command |
| bit_ack | input | 1 | One-cycle completion of the current command |
| bit_rdata | input | 1 | Sampled SDA for a read-bit command, valid with `bit_ack` |
| irq | output | 1 | Interrupt request |

## Verification
A wrong sequencer state shows at the bit-command port within one command. A skipped or extra header byte, a missing repeated START, or a wrong ACK level on the last received byte shows up as a command that differs from the next expected one. The bench compares every request against a queue of expected commands as it is accepted. A wrong byte counter or window index shows up at burst end as wrong received-window contents or a missing burst-done flag, which become visible through register reads a few cycles after the last acknowledge.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
    localparam int REG_AW    = 6;
    localparam int HDR_BYTES = 3;
    localparam int NUM_EV    = 7;
    localparam int TXW_BASE  = 16;
    localparam int RXW_BASE  = 32;

    localparam logic [REG_AW-1:0] RA_CTRL = 6'd0;
    localparam logic [REG_AW-1:0] RA_HDR  = 6'd1;
    localparam logic [REG_AW-1:0] RA_SUB  = 6'd2;
    localparam logic [REG_AW-1:0] RA_TXN  = 6'd3;
    localparam logic [REG_AW-1:0] RA_RXN  = 6'd4;
    localparam logic [REG_AW-1:0] RA_IEN  = 6'd5;
    localparam logic [REG_AW-1:0] RA_IPD  = 6'd6;

    localparam int EV_BTX   = 0;
    localparam int EV_BRX   = 1;
    localparam int EV_BURST_TX = 2;
    localparam int EV_BURST_RX = 3;
    localparam int EV_START = 4;
    localparam int EV_STOP  = 5;
    localparam int EV_NAK   = 6;

    typedef enum logic [1:0] {
        BC_START = 2'd0,
        BC_STOP  = 2'd1,
        BC_WRITE = 2'd2,
        BC_READ  = 2'd3
    } bit_cmd_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_TX    = 2'd2,
        OP_RX    = 2'd3
    } byte_op_e;

    typedef enum logic [1:0] {
        MODE_TX    = 2'd0,
        MODE_REGRD = 2'd1,
        MODE_RX    = 2'd2,
        MODE_HDRTX = 2'd3
    } mode_e;
endpackage

// File: rtl/i2cb_regs.sv
module i2cb_regs
    import i2cb_pkg::*;
#(
    parameter int WIN_WORDS = 8,
    parameter int CNT_W     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic                   en,
    output mode_e                  mode,
    output logic                   start_req,
    output logic                   stop_req,
    output logic                   lastnak,
    output logic                   nakstop,
    output logic [8*HDR_BYTES-1:0] hdr_bytes,
    output logic [HDR_BYTES-1:0]   hdr_vld,
    output logic [8*HDR_BYTES-1:0] sub_bytes,
    output logic [HDR_BYTES-1:0]   sub_vld,
    output logic                   txn_req,
    output logic                   rxn_req,
    output logic [CNT_W-1:0]       cnt_val,
    input  logic [$clog2(WIN_WORDS*4)-1:0] tx_idx,
    output logic [7:0]             tx_byte,
    input  logic                   rx_we,
    input  logic [$clog2(WIN_WORDS*4)-1:0] rx_idx,
    input  logic [7:0]             rx_byte,
    input  logic [NUM_EV-1:0]      ev,
    output logic                   irq
);
    localparam int WIN_BYTES = WIN_WORDS * 4;
    localparam int IDX_W     = $clog2(WIN_BYTES);
    localparam int WW        = $clog2(WIN_WORDS);
    localparam int HV_W      = 8 * HDR_BYTES + HDR_BYTES;

    logic [6:0]              ctrl_q;
    logic [HV_W-1:0]         hdr_q, sub_q;
    logic [CNT_W-1:0]        txn_q, rxn_q;
    logic [NUM_EV-1:0]       ien_q, pend_q;
    logic                    start_q, stop_q, txn_p_q, rxn_p_q;
    logic [WIN_WORDS*32-1:0] tx_flat, rx_flat;

    logic hit_ctrl, hit_txn, hit_rxn, hit_tx, hit_rx;
    logic [REG_AW-1:0] tx_off, rx_off;

    assign hit_ctrl = reg_we && (reg_addr == RA_CTRL);
    assign hit_txn  = reg_we && (reg_addr == RA_TXN);
    assign hit_rxn  = reg_we && (reg_addr == RA_RXN);
    assign tx_off   = reg_addr - REG_AW'(TXW_BASE);
    assign rx_off   = reg_addr - REG_AW'(RXW_BASE);
    assign hit_tx   = (int'(reg_addr) >= TXW_BASE) && (int'(reg_addr) < TXW_BASE + WIN_WORDS);
    assign hit_rx   = (int'(reg_addr) >= RXW_BASE) && (int'(reg_addr) < RXW_BASE + WIN_WORDS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            hdr_q   <= '0;
            sub_q   <= '0;
            txn_q   <= '0;
            rxn_q   <= '0;
            ien_q   <= '0;
            pend_q  <= '0;
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            txn_p_q <= 1'b0;
            rxn_p_q <= 1'b0;
        end else begin
            start_q <= hit_ctrl && reg_wdata[3] && !ctrl_q[3];
            stop_q  <= hit_ctrl && reg_wdata[4] && !ctrl_q[4];
            txn_p_q <= hit_txn;
            rxn_p_q <= hit_rxn;
            if (hit_ctrl) ctrl_q <= reg_wdata[6:0];
            if (reg_we && reg_addr == RA_HDR) hdr_q <= reg_wdata[HV_W-1:0];
            if (reg_we && reg_addr == RA_SUB) sub_q <= reg_wdata[HV_W-1:0];
            if (hit_txn) txn_q <= reg_wdata[CNT_W-1:0];
            if (hit_rxn) rxn_q <= reg_wdata[CNT_W-1:0];
            if (reg_we && reg_addr == RA_IEN) ien_q <= reg_wdata[NUM_EV-1:0];
            if (reg_we && reg_addr == RA_IPD)
                pend_q <= (pend_q & ~reg_wdata[NUM_EV-1:0]) | ev;
            else
                pend_q <= pend_q | ev;
        end
    end

    // One storage word per generate slot for each data window.
    for (genvar w = 0; w < WIN_WORDS; w++) begin : g_win
        logic [31:0] txw_q, rxw_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                txw_q <= '0;
                rxw_q <= '0;
            end else begin
                if (reg_we && hit_tx && tx_off[WW-1:0] == WW'(w))
                    txw_q <= reg_wdata;
                if (rx_we && rx_idx[IDX_W-1:2] == WW'(w))
                    rxw_q[{rx_idx[1:0], 3'b000} +: 8] <= rx_byte;
            end
        end
        assign tx_flat[32*w +: 32] = txw_q;
        assign rx_flat[32*w +: 32] = rxw_q;
    end

    assign tx_byte   = tx_flat[{tx_idx, 3'b000} +: 8];
    assign en        = ctrl_q[0];
    assign mode      = mode_e'(ctrl_q[2:1]);
    assign lastnak   = ctrl_q[5];
    assign nakstop   = ctrl_q[6];
    assign start_req = start_q;
    assign stop_req  = stop_q;
    assign txn_req   = txn_p_q;
    assign rxn_req   = rxn_p_q;
    assign cnt_val   = txn_p_q ? txn_q : rxn_q;
    assign hdr_bytes = hdr_q[8*HDR_BYTES-1:0];
    assign hdr_vld   = hdr_q[HV_W-1:8*HDR_BYTES];
    assign sub_bytes = sub_q[8*HDR_BYTES-1:0];
    assign sub_vld   = sub_q[HV_W-1:8*HDR_BYTES];
    assign irq       = |(pend_q & ien_q);

    always_comb begin
        reg_rdata = '0;
        if (hit_tx)      reg_rdata = tx_flat[{tx_off[WW-1:0], 5'b00000} +: 32];
        else if (hit_rx) reg_rdata = rx_flat[{rx_off[WW-1:0], 5'b00000} +: 32];
        else begin
            case (reg_addr)
                RA_CTRL: reg_rdata = {25'd0, ctrl_q};
                RA_HDR:  reg_rdata = 32'(hdr_q);
                RA_SUB:  reg_rdata = 32'(sub_q);
                RA_TXN:  reg_rdata = 32'(txn_q);
                RA_RXN:  reg_rdata = 32'(rxn_q);
                RA_IEN:  reg_rdata = 32'(ien_q);
                RA_IPD:  reg_rdata = 32'(pend_q);
                default: reg_rdata = '0;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_EV; i++) begin : g_pend_chk
        p_pend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> pend_q[i]);
        p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_addr == RA_IPD && reg_wdata[i] && !ev[i]) |=> !pend_q[i]);
    end
endmodule

// File: rtl/i2cb_byte.sv
module i2cb_byte
    import i2cb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  byte_op_e   op,
    input  logic [7:0] wbyte,
    input  logic       ack_out,
    output logic       done,
    output logic [7:0] rbyte,
    output logic       ack_in,
    output logic       busy,
    output logic       bit_req,
    output logic [1:0] bit_cmd,
    output logic       bit_wdata,
    input  logic       bit_ack,
    input  logic       bit_rdata
);
    typedef enum logic {E_IDLE, E_RUN} est_e;

    est_e       st_q;
    byte_op_e   op_q;
    logic [7:0] sh_q;
    logic [3:0] cnt_q;
    logic       ackout_q, ackin_q, done_q;
    logic       slot_ack;

    assign slot_ack = (cnt_q == 4'd8);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= E_IDLE;
            op_q     <= OP_START;
            sh_q     <= '0;
            cnt_q    <= '0;
            ackout_q <= 1'b0;
            ackin_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                E_IDLE: if (go) begin
                    st_q     <= E_RUN;
                    op_q     <= op;
                    sh_q     <= wbyte;
                    ackout_q <= ack_out;
                    cnt_q    <= '0;
                end
                E_RUN: if (bit_ack) begin
                    cnt_q <= cnt_q + 4'd1;
                    if (op_q == OP_TX && !slot_ack) sh_q <= {sh_q[6:0], 1'b0};
                    if (op_q == OP_RX && !slot_ack) sh_q <= {sh_q[6:0], bit_rdata};
                    if (op_q == OP_TX && slot_ack)  ackin_q <= bit_rdata;
                    if (op_q == OP_START || op_q == OP_STOP || slot_ack) begin
                        st_q   <= E_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= E_IDLE;
            endcase
        end
    end

    always_comb begin
        bit_req   = (st_q == E_RUN);
        bit_cmd   = BC_START;
        bit_wdata = 1'b0;
        unique case (op_q)
            OP_START: bit_cmd = BC_START;
            OP_STOP:  bit_cmd = BC_STOP;
            OP_TX: begin
                bit_cmd   = slot_ack ? BC_READ : BC_WRITE;
                bit_wdata = slot_ack ? 1'b0 : sh_q[7];
            end
            OP_RX: begin
                bit_cmd   = slot_ack ? BC_WRITE : BC_READ;
                bit_wdata = slot_ack ? ackout_q : 1'b0;
            end
            default: bit_cmd = BC_START;
        endcase
    end

    assign done   = done_q;
    assign rbyte  = sh_q;
    assign ack_in = ackin_q;
    assign busy   = (st_q != E_IDLE);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req && !bit_ack) |=> (bit_req && $stable(bit_cmd) && $stable(bit_wdata)));
    p_go_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (st_q == E_IDLE && !done_q));
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
    import i2cb_pkg::*;
#(
    parameter int WIN_WORDS = 8,
    parameter int CNT_W     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  mode_e                  mode,
    input  logic                   start_req,
    input  logic                   stop_req,
    input  logic                   lastnak,
    input  logic                   nakstop,
    input  logic [8*HDR_BYTES-1:0] hdr_bytes,
    input  logic [HDR_BYTES-1:0]   hdr_vld,
    input  logic [8*HDR_BYTES-1:0] sub_bytes,
    input  logic [HDR_BYTES-1:0]   sub_vld,
    input  logic                   txn_req,
    input  logic                   rxn_req,
    input  logic [CNT_W-1:0]       cnt_val,
    output logic [$clog2(WIN_WORDS*4)-1:0] tx_idx,
    input  logic [7:0]             tx_byte,
    output logic                   rx_we,
    output logic [$clog2(WIN_WORDS*4)-1:0] rx_idx,
    output logic [NUM_EV-1:0]      ev,
    output logic                   go,
    output byte_op_e               op,
    output logic [7:0]             wbyte,
    output logic                   ack_out,
    input  logic                   done,
    input  logic                   ack_in
);
    localparam int WIN_BYTES = WIN_WORDS * 4;
    localparam int IDX_W     = $clog2(WIN_BYTES);
    localparam logic [CNT_W-1:0] MAXN = CNT_W'(WIN_BYTES);

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_STOP, S_HDR_W, S_SUB,
        S_RESTART, S_HDR_R, S_TXDATA, S_RXDATA
    } seq_e;

    seq_e             state_q, state_d, hdr_next;
    logic             wait_q, wait_d;
    logic [1:0]       hidx_q, hidx_d;
    logic [CNT_W-1:0] n_q, n_d, total_q, total_d, clamp;
    mode_e            mode_q, mode_d;
    logic [3:0]       hv4, sv4;
    logic [7:0]       hb, sb;
    logic             vld_cur, last, tx_ok, rx_ok, abort;

    assign hv4     = 4'(hdr_vld);
    assign sv4     = 4'(sub_vld);
    assign hb      = hdr_bytes[{hidx_q, 3'b000} +: 8];
    assign sb      = sub_bytes[{hidx_q, 3'b000} +: 8];
    assign vld_cur = (state_q == S_SUB) ? sv4[hidx_q] : hv4[hidx_q];
    assign last    = (n_q == total_q - 1'b1);
    assign clamp   = (cnt_val > MAXN) ? MAXN : cnt_val;
    assign tx_ok   = (cnt_val != '0) && (mode == MODE_TX || mode == MODE_HDRTX);
    assign rx_ok   = (cnt_val != '0) && (mode == MODE_RX || mode == MODE_REGRD);
    assign abort   = done && ack_in && nakstop;
    assign tx_idx  = n_q[IDX_W-1:0];
    assign rx_idx  = n_q[IDX_W-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wait_q  <= 1'b0;
            hidx_q  <= '0;
            n_q     <= '0;
            total_q <= '0;
            mode_q  <= MODE_TX;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
            hidx_q  <= hidx_d;
            n_q     <= n_d;
            total_q <= total_d;
            mode_q  <= mode_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        wait_d  = wait_q;
        hidx_d  = hidx_q;
        n_d     = n_q;
        total_d = total_q;
        mode_d  = mode_q;
        unique case (state_q)
            S_HDR_W: hdr_next = S_SUB;
            S_SUB:   hdr_next = (mode_q == MODE_REGRD) ? S_RESTART : S_TXDATA;
            default: hdr_next = S_RXDATA;
        endcase
        if (go) wait_d = 1'b1;
        unique case (state_q)
            S_IDLE: if (en) begin
                if (start_req) state_d = S_START;
                else if (stop_req) state_d = S_STOP;
                else if ((txn_req && tx_ok) || (rxn_req && rx_ok)) begin
                    total_d = clamp;
                    n_d     = '0;
                    hidx_d  = '0;
                    mode_d  = mode;
                    if (mode == MODE_TX)      state_d = S_TXDATA;
                    else if (mode == MODE_RX) state_d = S_RXDATA;
                    else                      state_d = S_HDR_W;
                end
            end
            S_START, S_STOP: if (done) begin
                wait_d  = 1'b0;
                state_d = S_IDLE;
            end
            S_RESTART: if (done) begin
                wait_d  = 1'b0;
                hidx_d  = '0;
                state_d = S_HDR_R;
            end
            S_HDR_W, S_SUB, S_HDR_R: begin
                if (abort) begin
                    wait_d  = 1'b0;
                    state_d = S_STOP;
                end else if (done || (!wait_q && !vld_cur)) begin
                    wait_d = 1'b0;
                    if (hidx_q == 2'(HDR_BYTES - 1)) begin
                        hidx_d  = '0;
                        state_d = hdr_next;
                    end else begin
                        hidx_d = hidx_q + 2'd1;
                    end
                end
            end
            S_TXDATA: if (done) begin
                wait_d = 1'b0;
                n_d    = n_q + 1'b1;
                if (abort)     state_d = S_STOP;
                else if (last) state_d = S_IDLE;
            end
            S_RXDATA: if (done) begin
                wait_d = 1'b0;
                n_d    = n_q + 1'b1;
                if (last) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        go      = 1'b0;
        op      = OP_TX;
        wbyte   = 8'h00;
        ack_out = 1'b0;
        rx_we   = 1'b0;
        ev      = '0;
        unique case (state_q)
            S_IDLE: ;
            S_START:   begin go = !wait_q; op = OP_START; end
            S_STOP:    begin go = !wait_q; op = OP_STOP;  end
            S_RESTART: begin go = !wait_q; op = OP_START; end
            S_HDR_W: begin
                go    = !wait_q && vld_cur;
                wbyte = (hidx_q == 2'd0) ? {hb[7:1], 1'b0} : hb;
            end
            S_HDR_R: begin
                go    = !wait_q && vld_cur;
                wbyte = (hidx_q == 2'd0) ? {hb[7:1], 1'b1} : hb;
            end
            S_SUB: begin
                go    = !wait_q && vld_cur;
                wbyte = sb;
            end
            S_TXDATA: begin
                go    = !wait_q;
                wbyte = tx_byte;
            end
            S_RXDATA: begin
                go      = !wait_q;
                op      = OP_RX;
                ack_out = lastnak && last;
                rx_we   = done;
            end
            default: ;
        endcase
        if (done) begin
            case (state_q)
                S_START: ev[EV_START] = 1'b1;
                S_STOP:  ev[EV_STOP]  = 1'b1;
                S_HDR_W, S_SUB, S_HDR_R: begin
                    ev[EV_BTX] = 1'b1;
                    ev[EV_NAK] = ack_in;
                end
                S_TXDATA: begin
                    ev[EV_BTX]      = 1'b1;
                    ev[EV_NAK]      = ack_in;
                    ev[EV_BURST_TX] = last && !abort;
                end
                S_RXDATA: begin
                    ev[EV_BRX]      = 1'b1;
                    ev[EV_BURST_RX] = last;
                end
                default: ;
            endcase
        end
    end

    p_nakstop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TXDATA && done && ack_in && nakstop) |=> (state_q == S_STOP));
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> (int'(n_q) < WIN_BYTES));
    p_done_waited_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> wait_q);
    p_ack_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RXDATA && go && !lastnak) |-> !ack_out);
endmodule

// File: rtl/i2cb_top.sv
module i2cb_top
    import i2cb_pkg::*;
#(
    parameter int WIN_WORDS = 8,
    parameter int CNT_W     = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        bit_req,
    output logic [1:0]  bit_cmd,
    output logic        bit_wdata,
    input  logic        bit_ack,
    input  logic        bit_rdata,
    output logic        irq
);
    localparam int IDX_W = $clog2(WIN_WORDS * 4);

    logic                   en, start_req, stop_req, lastnak, nakstop;
    mode_e                  mode;
    logic [8*HDR_BYTES-1:0] hdr_bytes, sub_bytes;
    logic [HDR_BYTES-1:0]   hdr_vld, sub_vld;
    logic                   txn_req, rxn_req;
    logic [CNT_W-1:0]       cnt_val;
    logic [IDX_W-1:0]       tx_idx, rx_idx;
    logic [7:0]             tx_byte, rbyte, wbyte;
    logic                   rx_we, go, ack_out, done, ack_in, eng_busy;
    logic [NUM_EV-1:0]      ev;
    byte_op_e               op;

    i2cb_regs #(.WIN_WORDS(WIN_WORDS), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .en(en), .mode(mode), .start_req(start_req), .stop_req(stop_req),
        .lastnak(lastnak), .nakstop(nakstop),
        .hdr_bytes(hdr_bytes), .hdr_vld(hdr_vld), .sub_bytes(sub_bytes), .sub_vld(sub_vld),
        .txn_req(txn_req), .rxn_req(rxn_req), .cnt_val(cnt_val),
        .tx_idx(tx_idx), .tx_byte(tx_byte),
        .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rbyte),
        .ev(ev), .irq(irq)
    );

    i2cb_seq #(.WIN_WORDS(WIN_WORDS), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .en(en), .mode(mode), .start_req(start_req), .stop_req(stop_req),
        .lastnak(lastnak), .nakstop(nakstop),
        .hdr_bytes(hdr_bytes), .hdr_vld(hdr_vld), .sub_bytes(sub_bytes), .sub_vld(sub_vld),
        .txn_req(txn_req), .rxn_req(rxn_req), .cnt_val(cnt_val),
        .tx_idx(tx_idx), .tx_byte(tx_byte), .rx_we(rx_we), .rx_idx(rx_idx),
        .ev(ev), .go(go), .op(op), .wbyte(wbyte), .ack_out(ack_out),
        .done(done), .ack_in(ack_in)
    );

    i2cb_byte u_byte (
        .clk(clk), .rst_n(rst_n),
        .go(go), .op(op), .wbyte(wbyte), .ack_out(ack_out),
        .done(done), .rbyte(rbyte), .ack_in(ack_in), .busy(eng_busy),
        .bit_req(bit_req), .bit_cmd(bit_cmd), .bit_wdata(bit_wdata),
        .bit_ack(bit_ack), .bit_rdata(bit_rdata)
    );

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_busy) |-> !bit_req);
endmodule

// File: tb/i2cb_top_tb.sv
`timescale 1ns/1ps
module i2cb_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bit_req;
    logic [1:0]  bit_cmd;
    logic        bit_wdata;
    logic        bit_ack = 1'b0;
    logic        bit_rdata = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int unexpected = 0;
    bit done_run = 1'b0;

    typedef struct packed { logic [1:0] cmd; logic wd; logic rd; } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    i2cb_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_req(bit_req),
        .bit_cmd(bit_cmd), .bit_wdata(bit_wdata), .bit_ack(bit_ack),
        .bit_rdata(bit_rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Driver side: expected bus commands
    task automatic push(input logic [1:0] c, input logic w, input logic r);
        item_t it;
        it.cmd = c; it.wd = w; it.rd = r;
        exp_q.push_back(it);
    endtask

    task automatic push_tx(input logic [7:0] b, input logic nak);
        for (int i = 7; i >= 0; i--) push(2'd2, b[i], 1'b0);
        push(2'd3, 1'b0, nak);
    endtask

    task automatic push_rx(input logic [7:0] b, input logic ackbit);
        for (int i = 7; i >= 0; i--) push(2'd3, 1'b0, b[i]);
        push(2'd2, ackbit, 1'b0);
    endtask

    task automatic wait_pend(input int bitn, input string req);
        logic [31:0] v;
        int n;
        n = 0;
        v = '0;
        while (!v[bitn] && n < 4000) begin
            rd(6'd6, v);
            n++;
        end
        chk(v[bitn], req, v, 32'(1) << bitn);
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expected commands and answers as the bit-timing block
    initial begin
        forever begin
            @(negedge clk);
            if (bit_req) begin
                item_t e;
                if (exp_q.size() == 0) begin
                    unexpected++;
                    chk(1'b0, "R12 unexpected command", 32'(bit_cmd), 32'hFFFF_FFFF);
                    e = '0;
                end else begin
                    e = exp_q.pop_front();
                    chk(bit_cmd == e.cmd, "R12 command order", 32'(bit_cmd), 32'(e.cmd));
                    if (e.cmd == 2'd2)
                        chk(bit_wdata == e.wd, "R12 write bit level", 32'(bit_wdata), 32'(e.wd));
                end
                repeat (2) @(negedge clk);
                bit_ack = 1'b1;
                bit_rdata = e.rd;
                @(negedge clk);
                bit_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            chk(1'b0, "watchdog", 32'(exp_q.size()), 32'd0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(6'd0, v);  chk(v == 0, "R1 ctrl after reset", v, 0);
        rd(6'd6, v);  chk(v == 0, "R1 pending after reset", v, 0);
        rd(6'd16, v); chk(v == 0, "R1 tx window after reset", v, 0);
        chk(irq == 0, "R1 irq after reset", 32'(irq), 0);
        chk(bit_req == 0, "R1 no request after reset", 32'(bit_req), 0);

        // R2 start, R10 irq
        wr(6'd5, 32'h10);
        push(2'd0, 1'b0, 1'b0);
        wr(6'd0, 32'h09);
        wait_pend(4, "R2 start done pending");
        rd(6'd6, v); chk(v == 32'h10, "R2 only start pending", v, 32'h10);
        #1 chk(irq == 1, "R10 irq with enabled pending", 32'(irq), 1);
        idle_wait(40);
        chk(exp_q.size() == 0 && unexpected == 0, "R2 held start issues nothing more", 32'(unexpected), 0);
        wr(6'd0, 32'h01);
        wr(6'd6, 32'h10);
        rd(6'd6, v); chk(v == 0, "R8 write-1 clears start pending", v, 0);
        #1 chk(irq == 0, "R10 irq drops after clear", 32'(irq), 0);

        // R4 mode 0 burst, crossing a window word
        wr(6'd16, 32'h33C3_5AA0);
        wr(6'd17, 32'h0000_00E1);
        push_tx(8'hA0, 0); push_tx(8'h5A, 0); push_tx(8'hC3, 0);
        push_tx(8'h33, 0); push_tx(8'hE1, 0);
        wr(6'd3, 32'd5);
        wait_pend(2, "R4 transmit burst done");
        rd(6'd6, v); chk(v == 32'h05, "R4 byte and burst pending", v, 32'h05);
        chk(exp_q.size() == 0, "R4 all bytes sent", 32'(exp_q.size()), 0);
        wr(6'd6, 32'h01);
        rd(6'd6, v); chk(v == 32'h04, "R8 partial write-1 clear", v, 32'h04);
        wr(6'd6, 32'h7F);

        // R3 stop
        push(2'd1, 1'b0, 1'b0);
        wr(6'd0, 32'h11);
        wait_pend(5, "R3 stop done pending");
        rd(6'd6, v); chk(v == 32'h20, "R3 only stop pending", v, 32'h20);
        wr(6'd0, 32'h01);
        wr(6'd6, 32'h7F);

        // R11 ignored count writes
        wr(6'd0, 32'h00);
        wr(6'd3, 32'd2);
        idle_wait(60);
        rd(6'd6, v); chk(v == 0 && unexpected == 0, "R11 disabled count ignored", v, 0);
        wr(6'd0, 32'h05);
        wr(6'd3, 32'd2);
        wr(6'd4, 32'd0);
        idle_wait(60);
        rd(6'd6, v); chk(v == 0 && unexpected == 0, "R11 wrong mode and zero count ignored", v, 0);

        // R5 register read, R6 last NAK
        push(2'd0, 1'b0, 1'b0);
        wr(6'd0, 32'h2B);
        wait_pend(4, "R5 start before register read");
        wr(6'd0, 32'h23);
        wr(6'd6, 32'h7F);
        wr(6'd1, 32'h0100_0050);
        wr(6'd2, 32'h0300_3412);
        push_tx(8'h50, 0); push_tx(8'h12, 0); push_tx(8'h34, 0);
        push(2'd0, 1'b0, 1'b0);
        push_tx(8'h51, 0);
        push_rx(8'h9C, 0); push_rx(8'h3E, 1);
        wr(6'd4, 32'd2);
        wait_pend(3, "R5 receive burst done");
        rd(6'd32, v); chk(v == 32'h0000_3E9C, "R6 receive window packing", v, 32'h0000_3E9C);
        rd(6'd6, v); chk(v == 32'h0B, "R5 pending after register read", v, 32'h0B);
        chk(exp_q.size() == 0, "R5 full sequence consumed", 32'(exp_q.size()), 0);
        wr(6'd6, 32'h7F);

        // R7 mode 3 with a skipped register byte
        wr(6'd0, 32'h07);
        wr(6'd2, 32'h0200_3400);
        wr(6'd16, 32'h0000_0077);
        push_tx(8'h50, 0); push_tx(8'h34, 0); push_tx(8'h77, 0);
        wr(6'd3, 32'd1);
        wait_pend(2, "R7 header then data done");
        rd(6'd6, v); chk(v == 32'h05, "R7 pending", v, 32'h05);
        chk(exp_q.size() == 0, "R7 sequence consumed", 32'(exp_q.size()), 0);
        wr(6'd6, 32'h7F);

        // R9 NAK without abort
        wr(6'd0, 32'h01);
        wr(6'd16, 32'h0000_66A0);
        push_tx(8'hA0, 1); push_tx(8'h66, 0);
        wr(6'd3, 32'd2);
        wait_pend(2, "R9 burst continues after NAK");
        rd(6'd6, v); chk(v == 32'h45, "R9 NAK pending without abort", v, 32'h45);
        wr(6'd6, 32'h7F);

        // R9 NAK with abort
        wr(6'd0, 32'h41);
        push_tx(8'hA0, 1);
        push(2'd1, 1'b0, 1'b0);
        wr(6'd3, 32'd2);
        wait_pend(5, "R9 abort issues stop");
        rd(6'd6, v); chk(v == 32'h61, "R9 abort pending, no burst done", v, 32'h61);
        chk(exp_q.size() == 0, "R9 second byte not sent", 32'(exp_q.size()), 0);
        wr(6'd6, 32'h7F);

        // R6 mode 2 receive, ACK on every byte
        wr(6'd0, 32'h05);
        push_rx(8'hA5, 0); push_rx(8'h0F, 0); push_rx(8'hF0, 0);
        wr(6'd4, 32'd3);
        wait_pend(3, "R6 receive only burst done");
        rd(6'd32, v); chk(v == 32'h00F0_0FA5, "R6 receive only data", v, 32'h00F0_0FA5);
        rd(6'd6, v); chk(v == 32'h0A, "R6 receive pending", v, 32'h0A);

        // R10 masking
        wr(6'd5, 32'h08);
        #1 chk(irq == 1, "R10 enabled receive-burst bit", 32'(irq), 1);
        wr(6'd5, 32'h04);
        #1 chk(irq == 0, "R10 masked pending", 32'(irq), 0);

        idle_wait(20);
        chk(exp_q.size() == 0 && unexpected == 0, "R12 no leftover commands", 32'(unexpected), 0);
        done_run = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule